// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers per-channel interrupt events from a bank of DMA transfer engines and exposes them to software through enable and pending registers on a plain 32-bit register port. Each channel can raise three kinds of event: half of a transfer done, one descriptor (package) finished, and a whole queue finished. Every event is latched into a pending bit as soon as its one-cycle pulse arrives. A registered interrupt line is raised whenever any pending bit is also enabled.

Channels are packed eight to a 32-bit word, four bits per channel. The lower eight channels share one enable word and one pending word. The upper eight channels share a second pair. Software clears a pending bit by writing a one to it. Pending bits are readable whether or not they are enabled, so a driver can poll the block without taking the interrupt. The number of channels is fixed at build time to 8, 12 or 16.

Top module: `dma_irq_status`

## Requirements
- R1: Inside each 4-bit channel slot, bit 0 is half-transfer, bit 1 is package done, bit 2 is queue done, and bit 3 always reads as zero.
- R2: Channel c (0..7) sits at bits [4c+3:4c] of the enable word at offset 0x00 and of the pending word at offset 0x10. Channel c (8..15) sits at bits [4(c-8)+3:4(c-8)] of offsets 0x04 (enable) and 0x14 (pending).
- R3: An event pulse sets its pending bit whether or not that bit is enabled, and the set bit is visible on read.
- R4: A write to a pending word clears each bit written as one and leaves each bit written as zero unchanged.
- R5: When an event arrives in the same cycle as a write that clears its pending bit, the pending bit stays set.
- R6: An enable word stores the written value for the implemented event bits and reads it back. Writing an enable word does not alter any pending bit.
- R7: `irq` is the registered OR over all channels of (pending AND enable). It changes one clock after the pending or enable state that causes the change.
- R8: Slots of channels at or above NUM_CH read as zero and ignore writes.
- R9: Offsets other than 0x00, 0x04, 0x10 and 0x14 read as zero, and writes to them change no state.
- R10: After a synchronous reset, all enable and pending bits are zero and `irq` is low.
- R11: Once both enable words are written with zero and both pending words with all ones, with no new events, `irq` is low and both pending words read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_half | input | NUM_CH | One-cycle half-transfer pulses, one per channel |
| evt_pkg | input | NUM_CH | One-cycle package-done pulses, one per channel |
| evt_queue | input | NUM_CH | One-cycle queue-done pulses, one per channel |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume that the event inputs and the register strobe are settled, known values at every rising edge once reset is released. They also assume that `reg_addr` is a byte offset whose low two bits are zero for intended accesses. The stimulus drives every input on the falling edge and holds it for a full cycle. Each event is a single-cycle pulse, and the same-cycle collision of an event with a clearing write is produced on purpose, only where R5 is being tested. Unaligned or unmapped offsets appear only in the stimulus aimed at R9.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int SLOT_W      = 4;
    localparam int EVT_KINDS   = 3;
    localparam int CH_PER_BANK = DATA_W / SLOT_W;
    localparam int NUM_BANKS   = 2;
    localparam int MAX_CH      = CH_PER_BANK * NUM_BANKS;

    // Offsets; the bank split at channel 8 is part of the software contract.
    localparam logic [ADDR_W-1:0] OFS_EN_LO   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EN_HI   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h14;

    // Event bit order inside a slot is visible to software.
    typedef enum logic [1:0] {
        EVK_HALF  = 2'd0,
        EVK_PKG   = 2'd1,
        EVK_QUEUE = 2'd2
    } evt_kind_e;

    typedef struct packed {
        logic queue;
        logic pkg;
        logic half;
    } evt_bits_t;

    typedef struct packed {
        logic hit;      // one of the four mapped words
        logic is_pend;  // pending word (else enable word)
        logic bank;     // 0: channels 0..7, 1: channels 8..15
        logic en_wr;
        logic pend_wr;
    } reg_cmd_t;

    function automatic int bank_of(input int ch);
        return ch / CH_PER_BANK;
    endfunction

    function automatic int lsb_of(input int ch);
        return (ch % CH_PER_BANK) * SLOT_W;
    endfunction

endpackage

// File: rtl/dma_irq_regdec.sv
module dma_irq_regdec
    import dma_irq_pkg::*;
(
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    output reg_cmd_t          cmd
);

    logic sel_en_lo, sel_en_hi, sel_pend_lo, sel_pend_hi;

    always_comb begin
        sel_en_lo   = (reg_addr == OFS_EN_LO);
        sel_en_hi   = (reg_addr == OFS_EN_HI);
        sel_pend_lo = (reg_addr == OFS_PEND_LO);
        sel_pend_hi = (reg_addr == OFS_PEND_HI);

        cmd.hit     = sel_en_lo | sel_en_hi | sel_pend_lo | sel_pend_hi;
        cmd.is_pend = sel_pend_lo | sel_pend_hi;
        cmd.bank    = sel_en_hi | sel_pend_hi;
        cmd.en_wr   = reg_wr & (sel_en_lo | sel_en_hi);
        cmd.pend_wr = reg_wr & (sel_pend_lo | sel_pend_hi);
    end

endmodule

// File: rtl/dma_irq_slot.sv
module dma_irq_slot
    import dma_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_wr,
    input  logic      pend_wr,
    input  evt_bits_t wr_bits,
    input  evt_bits_t evt,
    output evt_bits_t en,
    output evt_bits_t pend,
    output logic      active
);

    evt_bits_t clr_mask;

    always_comb begin
        clr_mask = pend_wr ? wr_bits : '0;
        active   = |(pend & en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            pend <= '0;
        end else begin
            if (en_wr)
                en <= wr_bits;
            // a fresh event wins over a simultaneous clear
            pend <= (pend & ~clr_mask) | evt;
        end
    end

    p_evt_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (pend_wr && evt == '0) |=> ((pend & $past(wr_bits)) == '0));

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!pend_wr && evt == '0) |=> $stable(pend));

    p_en_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en));

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] evt_half,
    input  logic [NUM_CH-1:0] evt_pkg,
    input  logic [NUM_CH-1:0] evt_queue,
    output logic              irq
);

    localparam int HI_CH = NUM_CH - CH_PER_BANK;

    reg_cmd_t    cmd;
    evt_bits_t   slot_en   [NUM_CH];
    evt_bits_t   slot_pend [NUM_CH];
    logic [NUM_CH-1:0] slot_active;
    logic [DATA_W-1:0] en_word   [NUM_BANKS];
    logic [DATA_W-1:0] pend_word [NUM_BANKS];
    logic              irq_q;

    dma_irq_regdec u_dec (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .cmd      (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BANK = bank_of(c);
        localparam int LSB  = lsb_of(c);

        logic      bank_sel;
        evt_bits_t wbits;
        evt_bits_t evts;

        always_comb begin
            bank_sel   = (cmd.bank == 1'(BANK));
            wbits      = evt_bits_t'(reg_wdata[LSB +: EVT_KINDS]);
            evts.half  = evt_half[c];
            evts.pkg   = evt_pkg[c];
            evts.queue = evt_queue[c];
        end

        dma_irq_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .en_wr   (cmd.en_wr & bank_sel),
            .pend_wr (cmd.pend_wr & bank_sel),
            .wr_bits (wbits),
            .evt     (evts),
            .en      (slot_en[c]),
            .pend    (slot_pend[c]),
            .active  (slot_active[c])
        );
    end

    // Assemble the readable words; unimplemented slots and bit 3 stay zero.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            en_word[b]   = '0;
            pend_word[b] = '0;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            en_word[bank_of(c)][lsb_of(c) +: EVT_KINDS]   = slot_en[c];
            pend_word[bank_of(c)][lsb_of(c) +: EVT_KINDS] = slot_pend[c];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (cmd.hit)
            reg_rdata = cmd.is_pend ? pend_word[cmd.bank] : en_word[cmd.bank];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |slot_active;
    end

    assign irq = irq_q;

    p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|slot_active)));

    p_slot_bit3_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & 32'h8888_8888) == '0);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !cmd.hit |-> (reg_rdata == '0));

    if (HI_CH < CH_PER_BANK) begin : g_unimpl_chk
        p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (cmd.hit && cmd.bank) |-> ((reg_rdata >> (HI_CH * SLOT_W)) == '0));
    end

endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb_top;

    localparam int NCH = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  evt_half = '0;
    logic [NCH-1:0]  evt_pkg = '0;
    logic [NCH-1:0]  evt_queue = '0;
    logic            irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dma_irq_status #(.NUM_CH(NCH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_half  (evt_half),
        .evt_pkg   (evt_pkg),
        .evt_queue (evt_queue),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    // Monitor: pops expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver tasks
    task automatic tick();
        @(negedge clk);
    endtask

    // One cycle of stimulus: optional write, optional event (kind<0: none).
    task automatic cycle(input bit do_wr, input logic [7:0] a, input logic [31:0] d,
                         input int kind, input int ch);
        @(negedge clk);
        reg_wr    = do_wr;
        reg_addr  = a;
        reg_wdata = d;
        if (kind == 0) evt_half[ch]  = 1'b1;
        if (kind == 1) evt_pkg[ch]   = 1'b1;
        if (kind == 2) evt_queue[ch] = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        evt_half  = '0;
        evt_pkg   = '0;
        evt_queue = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, -1, 0);
    endtask

    task automatic pulse(input int kind, input int ch);
        cycle(1'b0, 8'h00, 32'h0, kind, ch);
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic expect_irq(input bit e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    function automatic logic [31:0] bitof(input int ch, input int kind);
        return 32'h1 << (((ch % 8) * 4) + kind);
    endfunction

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        expect_irq(1'b0, "R10 irq after reset");
        expect_rd(8'h00, 32'h0, "R10 enable lo");
        expect_rd(8'h04, 32'h0, "R10 enable hi");
        expect_rd(8'h10, 32'h0, "R10 pending lo");
        expect_rd(8'h14, 32'h0, "R10 pending hi");

        // R3/R1/R2: events latch while disabled, visible to polling
        pulse(0, 3);
        expect_rd(8'h10, bitof(3, 0), "R3 R1 ch3 half pending");
        pulse(2, 10);
        expect_rd(8'h14, bitof(10, 2), "R2 ch10 queue in hi word");
        pulse(1, 5);
        expect_rd(8'h10, bitof(3, 0) | bitof(5, 1), "R3 ch5 pkg pending");
        tick();
        expect_irq(1'b0, "R3 no irq while disabled");

        // R6/R7: enable low word
        wr(8'h00, 32'hFFFF_FFFF);
        expect_irq(1'b0, "R7 one-cycle latency");
        tick();
        expect_irq(1'b1, "R7 irq raised");
        expect_rd(8'h00, 32'h7777_7777, "R6 R1 enable lo readback");
        expect_rd(8'h10, bitof(3, 0) | bitof(5, 1), "R6 pending untouched");

        // R8: upper word, only channels 8..11 implemented
        wr(8'h04, 32'hFFFF_FFFF);
        expect_rd(8'h04, 32'h0000_7777, "R8 unimplemented slots zero");

        // R4: write-one-to-clear
        wr(8'h10, bitof(3, 0));
        expect_rd(8'h10, bitof(5, 1), "R4 clear only ones");

        // R5: event beats clear in same cycle
        cycle(1'b1, 8'h10, bitof(5, 1), 1, 5);
        expect_rd(8'h10, bitof(5, 1), "R5 event wins");
        wr(8'h10, bitof(5, 1));
        expect_rd(8'h10, 32'h0, "R4 cleared");

        wr(8'h14, 32'h0);
        expect_rd(8'h14, bitof(10, 2), "R4 zero write keeps");

        // R9: unmapped offsets
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h11, 32'hFFFF_FFFF);
        expect_rd(8'h08, 32'h0, "R9 unmapped read zero");
        expect_rd(8'h18, 32'h0, "R9 unmapped read zero 0x18");
        expect_rd(8'h00, 32'h7777_7777, "R9 enable lo unchanged");
        expect_rd(8'h14, bitof(10, 2), "R9 pending hi unchanged");

        // R7: falling edge when last active bit clears
        tick();
        expect_irq(1'b1, "R7 irq from ch10");
        wr(8'h14, bitof(10, 2));
        expect_irq(1'b1, "R7 fall latency");
        tick();
        expect_irq(1'b0, "R7 irq dropped");

        pulse(0, 11);
        expect_irq(1'b0, "R7 rise latency ch11");
        tick();
        expect_irq(1'b1, "R7 irq from ch11 half");
        expect_rd(8'h14, bitof(11, 0), "R2 ch11 slot 3");

        // R11: software quiesce sequence
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        tick();
        expect_irq(1'b0, "R11 irq low after quiesce");
        expect_rd(8'h10, 32'h0, "R11 pending lo zero");
        expect_rd(8'h14, 32'h0, "R11 pending hi zero");

        // R1/R2: remaining kinds and positions
        pulse(2, 0);
        expect_rd(8'h10, 32'h0000_0004, "R1 ch0 queue bit2");
        pulse(0, 8);
        expect_rd(8'h14, 32'h0000_0001, "R2 ch8 half slot0");

        // R10: reset mid-run clears state
        wr(8'h00, 32'h0000_0004);
        tick();
        tick();
        expect_irq(1'b1, "R7 irq before reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        expect_irq(1'b0, "R10 irq after mid reset");
        expect_rd(8'h00, 32'h0, "R10 enable cleared");
        expect_rd(8'h10, 32'h0, "R10 pending lo cleared");
        expect_rd(8'h14, 32'h0, "R10 pending hi cleared");

        tick();
        tick();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule